// File: doc/BRIEF.md
# Banked Exception Entry Unit

This unit holds the live program counter, the status word, the saved-status register and two general registers (r29 and r30) of a small 32-bit core. It also keeps one stored copy of r29, r30 and saved-status for each register bank. When software asks for a new operating mode, the unit puts the live trio into the bank of the old mode and fetches the trio of the new mode. When an exception is raised, the unit does the same bank exchange for the mode that the cause selects. It also saves the interrupted status word, masks interrupts, stores the return address and sends the program counter to the vector for that cause.

Every accepted operation finishes at one clock edge. The edge raises a one-cycle `done_o` pulse. A request that names an unknown cause or mode, or that comes while the status word holds an unknown mode, raises a one-cycle `err_o` pulse and changes no state. A plain update port lets the surrounding core write the live registers.

Top module: `exc_bank_unit`

## Requirements
- R1: After reset the status word reads 0x00000013 (privileged mode), and the program counter, r29, r30, saved-status and every bank entry read zero. `done_o` and `err_o` are low.
- R2: Mode codes sit in status bits [4:0] and map to banks as follows: user 0x10 and super-user 0x1F share bank 0, privileged 0x13 uses bank 1, trap 0x17 uses bank 2, extension 0x1B uses bank 3 and interrupt 0x12 uses bank 4. A switch between two modes that share a bank leaves r29, r30 and saved-status unchanged.
- R3: A mode request (`mode_req_i` with `mode_new_i`) to a different valid mode does three things at the next edge. It stores live r29, r30 and saved-status into the old mode's bank and loads them from the new mode's bank. It replaces status bits [4:0] with the new mode and keeps every other status bit. It pulses `done_o` for one cycle.
- R4: A mode request that names the current mode changes no register and still pulses `done_o`.
- R5: Exception causes on `exc_cause_i` are: 0 privileged call (privileged mode, offset 0x08), 1 instruction abort (trap mode, offset 0x0C), 2 data abort (trap mode, offset 0x10), 3 interrupt (interrupt mode, offset 0x18).
- R6: When bit 13 of `ctrl_i` is set at the request, 0xFFFF0000 is added to the vector offset.
- R7: On exception entry, saved-status receives the status word from before the exception. The status word receives the target mode in bits [4:0] and has its interrupt-disable bit 7 set.
- R8: On exception entry, r30 receives the interrupted program counter and the program counter receives the vector. r29 comes from the target mode's bank when the mode changes, and the old mode's trio is stored into its bank.
- R9: An exception taken while already in its target mode stores and loads no bank. r29 keeps its value.
- R10: A cause code of 4 to 7, a mode request with an unknown code, or either request while status bits [4:0] hold an unknown code pulses `err_o` for one cycle. It leaves all state unchanged and raises no `done_o`.
- R11: When requests coincide, an exception wins over a mode request, and a mode request wins over an update. The losing request has no effect.
- R12: An update (`upd_en_i`) writes `upd_data_i` at the next edge into the live register that `upd_sel_i` selects: 0 r29, 1 r30, 2 program counter, 3 status word. It does not pulse `done_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| exc_req_i | input | 1 | Exception request for this cycle |
| exc_cause_i | input | 3 | Exception cause code |
| mode_req_i | input | 1 | Mode change request for this cycle |
| mode_new_i | input | 5 | Requested mode code |
| ctrl_i | input | 32 | System control word; bit 13 selects high vectors |
| upd_en_i | input | 1 | Write enable for a live register |
| upd_sel_i | input | 2 | Selects which live register is written |
| upd_data_i | input | 32 | Value for the update |
| pc_o | output | 32 | Live program counter |
| r29_o | output | 32 | Live r29 |
| r30_o | output | 32 | Live r30 (return address after entry) |
| bsr_o | output | 32 | Live saved-status register |
| status_o | output | 32 | Live status word |
| done_o | output | 1 | One-cycle pulse after an accepted request |
| err_o | output | 1 | One-cycle pulse after a rejected request |

## Verification
Two pairs of functions can meet in one cycle. An exception can meet a mode change, and a mode change can meet a register update. The bench raises such pairs on purpose, once by hand and then many times in a long stretch of random stimulus. The winner's effect must show at the ports and no trace of the loser may remain. The behavioural model in the bench applies the stated priority. Its banks, live registers and pulses are compared with the design after every clock.

// File: rtl/exc_bank_pkg.sv
`timescale 1ns/1ps
package exc_bank_pkg;
  localparam int XLEN       = 32;
  localparam int MODE_W     = 5;
  localparam int CAUSE_W    = 3;
  localparam int BANK_IDX_W = 3;

  typedef logic [MODE_W-1:0]  mode_t;
  typedef logic [XLEN-1:0]    word_t;
  typedef logic [CAUSE_W-1:0] cause_t;

  localparam mode_t M_USER  = 5'h10;
  localparam mode_t M_SUPER = 5'h1F;
  localparam mode_t M_PRIV  = 5'h13;
  localparam mode_t M_TRAP  = 5'h17;
  localparam mode_t M_EXT   = 5'h1B;
  localparam mode_t M_IRQ   = 5'h12;

  localparam cause_t C_PCALL = 3'd0;
  localparam cause_t C_IABT  = 3'd1;
  localparam cause_t C_DABT  = 3'd2;
  localparam cause_t C_IRQ   = 3'd3;

  typedef enum logic [1:0] {
    U_R29    = 2'd0,
    U_R30    = 2'd1,
    U_PC     = 2'd2,
    U_STATUS = 2'd3
  } upd_sel_e;

  typedef struct packed {
    word_t r29;
    word_t r30;
    word_t sr;
  } bank_rec_t;

  function automatic logic mode_known(mode_t m);
    case (m)
      M_USER, M_SUPER, M_PRIV, M_TRAP, M_EXT, M_IRQ: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [BANK_IDX_W-1:0] bank_of(mode_t m);
    case (m)
      M_PRIV:  return 3'd1;
      M_TRAP:  return 3'd2;
      M_EXT:   return 3'd3;
      M_IRQ:   return 3'd4;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic cause_known(cause_t c);
    return (c <= C_IRQ);
  endfunction

  function automatic mode_t cause_mode(cause_t c);
    case (c)
      C_PCALL:       return M_PRIV;
      C_IABT, C_DABT: return M_TRAP;
      C_IRQ:         return M_IRQ;
      default:       return M_PRIV;
    endcase
  endfunction

  function automatic word_t cause_offset(cause_t c);
    case (c)
      C_PCALL: return 32'h0000_0008;
      C_IABT:  return 32'h0000_000C;
      C_DABT:  return 32'h0000_0010;
      C_IRQ:   return 32'h0000_0018;
      default: return '0;
    endcase
  endfunction

  function automatic word_t with_mode(word_t s, mode_t m);
    return {s[XLEN-1:MODE_W], m};
  endfunction
endpackage

// File: rtl/exc_cause_decode.sv
`timescale 1ns/1ps
module exc_cause_decode
  import exc_bank_pkg::*;
#(
  parameter int    HIVEC_BIT = 13,
  parameter word_t HI_BASE   = 32'hFFFF_0000
) (
  input  cause_t cause_i,
  input  word_t  ctrl_i,
  output logic   known_o,
  output mode_t  mode_o,
  output word_t  vec_o
);
  logic hi_sel;

  always_comb begin
    hi_sel  = ctrl_i[HIVEC_BIT];
    known_o = cause_known(cause_i);
    mode_o  = cause_mode(cause_i);
    vec_o   = cause_offset(cause_i) + (hi_sel ? HI_BASE : '0);
  end
endmodule

// File: rtl/exc_bank_store.sv
`timescale 1ns/1ps
module exc_bank_store
  import exc_bank_pkg::*;
#(
  parameter  int NUM_BANKS = 5,
  localparam int IW        = BANK_IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  bank_rec_t     wdata_i,
  input  logic [IW-1:0] ridx_i,
  output bank_rec_t     rdata_o
);
  bank_rec_t            slot [NUM_BANKS];
  logic [NUM_BANKS-1:0] hit;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_hit
    assign hit[b] = we_i && (widx_i == IW'(b));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int b = 0; b < NUM_BANKS; b++) slot[b] <= '0;
    end else begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (hit[b]) slot[b] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (ridx_i == IW'(b)) rdata_o = slot[b];
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
`timescale 1ns/1ps
module exc_entry_ctrl
  import exc_bank_pkg::*;
#(
  parameter int IRQ_BIT = 7
) (
  input  logic                  exc_req_i,
  input  logic                  mode_req_i,
  input  logic                  upd_en_i,
  input  logic [1:0]            upd_sel_i,
  input  word_t                 upd_data_i,
  input  mode_t                 mode_new_i,
  input  logic                  cause_known_i,
  input  mode_t                 cause_mode_i,
  input  word_t                 vec_i,
  input  word_t                 pc_i,
  input  word_t                 r29_i,
  input  word_t                 r30_i,
  input  word_t                 bsr_i,
  input  word_t                 status_i,
  input  bank_rec_t             bank_rd_i,
  output logic                  ev_exc_o,
  output logic                  ev_mode_o,
  output logic                  ev_upd_o,
  output logic                  ev_fault_o,
  output logic                  ev_swap_o,
  output logic                  ev_accept_o,
  output logic                  bank_we_o,
  output logic [BANK_IDX_W-1:0] bank_widx_o,
  output logic [BANK_IDX_W-1:0] bank_ridx_o,
  output bank_rec_t             bank_wdata_o,
  output word_t                 nxt_pc_o,
  output word_t                 nxt_r29_o,
  output word_t                 nxt_r30_o,
  output word_t                 nxt_bsr_o,
  output word_t                 nxt_status_o
);
  mode_t     cur_mode, tgt_mode;
  logic      tgt_ok, cur_ok, req_any;
  bank_rec_t live, loaded;
  logic      same_bank;

  always_comb begin
    cur_mode  = status_i[MODE_W-1:0];
    ev_exc_o  = exc_req_i;
    ev_mode_o = !exc_req_i && mode_req_i;
    ev_upd_o  = !exc_req_i && !mode_req_i && upd_en_i;
    req_any   = ev_exc_o || ev_mode_o;

    tgt_mode  = ev_exc_o ? cause_mode_i : mode_new_i;
    tgt_ok    = ev_exc_o ? cause_known_i : mode_known(mode_new_i);
    cur_ok    = mode_known(cur_mode);

    ev_fault_o  = req_any && !(tgt_ok && cur_ok);
    ev_accept_o = req_any && !ev_fault_o;
    ev_swap_o   = ev_accept_o && (tgt_mode != cur_mode);

    live         = '{r29: r29_i, r30: r30_i, sr: bsr_i};
    bank_we_o    = ev_swap_o;
    bank_widx_o  = bank_of(cur_mode);
    bank_ridx_o  = bank_of(tgt_mode);
    bank_wdata_o = live;
    same_bank    = (bank_widx_o == bank_ridx_o);
    loaded       = (ev_swap_o && !same_bank) ? bank_rd_i : live;
  end

  always_comb begin
    nxt_pc_o     = pc_i;
    nxt_r29_o    = r29_i;
    nxt_r30_o    = r30_i;
    nxt_bsr_o    = bsr_i;
    nxt_status_o = status_i;
    if (ev_accept_o) begin
      nxt_r29_o    = loaded.r29;
      nxt_r30_o    = ev_exc_o ? pc_i : loaded.r30;
      nxt_bsr_o    = ev_exc_o ? status_i : loaded.sr;
      nxt_status_o = with_mode(status_i, tgt_mode);
      if (ev_exc_o) begin
        nxt_status_o[IRQ_BIT] = 1'b1;
        nxt_pc_o              = vec_i;
      end
    end else if (ev_upd_o) begin
      case (upd_sel_e'(upd_sel_i))
        U_R29:    nxt_r29_o    = upd_data_i;
        U_R30:    nxt_r30_o    = upd_data_i;
        U_PC:     nxt_pc_o     = upd_data_i;
        U_STATUS: nxt_status_o = upd_data_i;
        default:  nxt_pc_o     = pc_i;
      endcase
    end
  end
endmodule

// File: rtl/exc_bank_unit.sv
`timescale 1ns/1ps
module exc_bank_unit
  import exc_bank_pkg::*;
#(
  parameter int    NUM_BANKS = 5,
  parameter int    HIVEC_BIT = 13,
  parameter int    IRQ_BIT   = 7,
  parameter word_t HI_BASE   = 32'hFFFF_0000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exc_req_i,
  input  logic [2:0]  exc_cause_i,
  input  logic        mode_req_i,
  input  logic [4:0]  mode_new_i,
  input  logic [31:0] ctrl_i,
  input  logic        upd_en_i,
  input  logic [1:0]  upd_sel_i,
  input  logic [31:0] upd_data_i,
  output logic [31:0] pc_o,
  output logic [31:0] r29_o,
  output logic [31:0] r30_o,
  output logic [31:0] bsr_o,
  output logic [31:0] status_o,
  output logic        done_o,
  output logic        err_o
);
  localparam word_t RESET_STATUS = word_t'(M_PRIV);

  logic                  dec_known;
  mode_t                 dec_mode;
  word_t                 dec_vec;
  bank_rec_t             bank_rd, bank_wdata;
  logic                  bank_we;
  logic [BANK_IDX_W-1:0] bank_widx, bank_ridx;
  logic                  ev_exc, ev_mode, ev_upd, ev_fault, ev_swap, ev_accept;
  word_t                 nxt_pc, nxt_r29, nxt_r30, nxt_bsr, nxt_status;

  exc_cause_decode #(
    .HIVEC_BIT(HIVEC_BIT),
    .HI_BASE  (HI_BASE)
  ) u_decode (
    .cause_i (exc_cause_i),
    .ctrl_i  (ctrl_i),
    .known_o (dec_known),
    .mode_o  (dec_mode),
    .vec_o   (dec_vec)
  );

  exc_bank_store #(
    .NUM_BANKS(NUM_BANKS)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (bank_we),
    .widx_i  (bank_widx),
    .wdata_i (bank_wdata),
    .ridx_i  (bank_ridx),
    .rdata_o (bank_rd)
  );

  exc_entry_ctrl #(
    .IRQ_BIT(IRQ_BIT)
  ) u_ctrl (
    .exc_req_i     (exc_req_i),
    .mode_req_i    (mode_req_i),
    .upd_en_i      (upd_en_i),
    .upd_sel_i     (upd_sel_i),
    .upd_data_i    (upd_data_i),
    .mode_new_i    (mode_new_i),
    .cause_known_i (dec_known),
    .cause_mode_i  (dec_mode),
    .vec_i         (dec_vec),
    .pc_i          (pc_o),
    .r29_i         (r29_o),
    .r30_i         (r30_o),
    .bsr_i         (bsr_o),
    .status_i      (status_o),
    .bank_rd_i     (bank_rd),
    .ev_exc_o      (ev_exc),
    .ev_mode_o     (ev_mode),
    .ev_upd_o      (ev_upd),
    .ev_fault_o    (ev_fault),
    .ev_swap_o     (ev_swap),
    .ev_accept_o   (ev_accept),
    .bank_we_o     (bank_we),
    .bank_widx_o   (bank_widx),
    .bank_ridx_o   (bank_ridx),
    .bank_wdata_o  (bank_wdata),
    .nxt_pc_o      (nxt_pc),
    .nxt_r29_o     (nxt_r29),
    .nxt_r30_o     (nxt_r30),
    .nxt_bsr_o     (nxt_bsr),
    .nxt_status_o  (nxt_status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o     <= '0;
      r29_o    <= '0;
      r30_o    <= '0;
      bsr_o    <= '0;
      status_o <= RESET_STATUS;
      done_o   <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      pc_o     <= nxt_pc;
      r29_o    <= nxt_r29;
      r30_o    <= nxt_r30;
      bsr_o    <= nxt_bsr;
      status_o <= nxt_status;
      done_o   <= ev_accept;
      err_o    <= ev_fault;
    end
  end
endmodule

// File: rtl/exc_bank_chk.sv
`timescale 1ns/1ps
module exc_bank_chk #(
  parameter int HIVEC_BIT = 13,
  parameter int IRQ_BIT   = 7
) (
  input logic        clk,
  input logic        rst_n,
  input logic        exc_req_i,
  input logic        mode_req_i,
  input logic [4:0]  mode_new_i,
  input logic [31:0] ctrl_i,
  input logic [31:0] pc_o,
  input logic [31:0] r29_o,
  input logic [31:0] r30_o,
  input logic [31:0] bsr_o,
  input logic [31:0] status_o,
  input logic        done_o,
  input logic        err_o,
  input logic        ev_swap
);
  assert_done_err_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_o && err_o));

  assert_err_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> (pc_o == $past(pc_o)) && (status_o == $past(status_o))
              && (r29_o == $past(r29_o)) && (r30_o == $past(r30_o)));

  assert_done_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(exc_req_i || mode_req_i));

  assert_mode_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_req_i && !exc_req_i) && done_o) |-> (status_o[4:0] == $past(mode_new_i)));

  assert_same_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_req_i && !exc_req_i && (mode_new_i == status_o[4:0])) && done_o)
      |-> (r29_o == $past(r29_o)) && (r30_o == $past(r30_o)) && (bsr_o == $past(bsr_o))
          && (status_o == $past(status_o)));

  assert_ret_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(exc_req_i) && done_o) |-> (r30_o == $past(pc_o)));

  assert_status_save_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(exc_req_i) && done_o) |-> status_o[IRQ_BIT] && (bsr_o == $past(status_o)));

  assert_high_vec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(exc_req_i && ctrl_i[HIVEC_BIT]) && done_o) |-> (pc_o[31:16] == 16'hFFFF));

  assert_swap_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_swap |=> done_o);
endmodule

bind exc_bank_unit exc_bank_chk #(
  .HIVEC_BIT(HIVEC_BIT),
  .IRQ_BIT  (IRQ_BIT)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .exc_req_i  (exc_req_i),
  .mode_req_i (mode_req_i),
  .mode_new_i (mode_new_i),
  .ctrl_i     (ctrl_i),
  .pc_o       (pc_o),
  .r29_o      (r29_o),
  .r30_o      (r30_o),
  .bsr_o      (bsr_o),
  .status_o   (status_o),
  .done_o     (done_o),
  .err_o      (err_o),
  .ev_swap    (ev_swap)
);

// File: tb/test_exc_bank_unit.sv
`timescale 1ns/1ps
module test_exc_bank_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_req = 1'b0;
  logic [2:0]  exc_cause = '0;
  logic        mode_req = 1'b0;
  logic [4:0]  mode_new = '0;
  logic [31:0] ctrl = '0;
  logic        upd_en = 1'b0;
  logic [1:0]  upd_sel = '0;
  logic [31:0] upd_data = '0;
  logic [31:0] pc, r29, r30, bsr, status;
  logic        done, err;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  exc_bank_unit i_exc_bank_unit (
    .clk(clk), .rst_n(rst_n),
    .exc_req_i(exc_req), .exc_cause_i(exc_cause),
    .mode_req_i(mode_req), .mode_new_i(mode_new), .ctrl_i(ctrl),
    .upd_en_i(upd_en), .upd_sel_i(upd_sel), .upd_data_i(upd_data),
    .pc_o(pc), .r29_o(r29), .r30_o(r30), .bsr_o(bsr), .status_o(status),
    .done_o(done), .err_o(err)
  );

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_pc, m_r29, m_r30, m_bsr, m_st;
  logic        m_done, m_err;
  logic [31:0] k29 [5];
  logic [31:0] k30 [5];
  logic [31:0] ksr [5];

  function automatic int slot_for(logic [4:0] m);
    if (m == 5'h10 || m == 5'h1F) return 0;
    if (m == 5'h13) return 1;
    if (m == 5'h17) return 2;
    if (m == 5'h1B) return 3;
    if (m == 5'h12) return 4;
    return -1;
  endfunction

  task automatic m_switch(logic [4:0] nm);
    int o, n;
    if (nm == m_st[4:0]) return;
    o = slot_for(m_st[4:0]);
    n = slot_for(nm);
    k29[o] = m_r29; k30[o] = m_r30; ksr[o] = m_bsr;
    m_r29 = k29[n]; m_r30 = k30[n]; m_bsr = ksr[n];
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pc = 0; m_r29 = 0; m_r30 = 0; m_bsr = 0; m_st = 32'h13;
      m_done = 0; m_err = 0;
      for (int i = 0; i < 5; i++) begin k29[i] = 0; k30[i] = 0; ksr[i] = 0; end
    end else begin
      m_done = 0; m_err = 0;
      if (exc_req) begin
        logic [4:0]  tm;
        logic [31:0] off, os, op;
        tm = 5'h13; off = 0;
        case (exc_cause)
          3'd0: begin tm = 5'h13; off = 32'h08; end
          3'd1: begin tm = 5'h17; off = 32'h0C; end
          3'd2: begin tm = 5'h17; off = 32'h10; end
          3'd3: begin tm = 5'h12; off = 32'h18; end
          default: ;
        endcase
        if (exc_cause > 3 || slot_for(m_st[4:0]) < 0) m_err = 1;
        else begin
          os = m_st; op = m_pc;
          m_switch(tm);
          m_bsr = os;
          m_st  = {os[31:8], 1'b1, os[6:5], tm};
          m_r30 = op;
          m_pc  = off + (ctrl[13] ? 32'hFFFF0000 : 32'h0);
          m_done = 1;
        end
      end else if (mode_req) begin
        if (slot_for(mode_new) < 0 || slot_for(m_st[4:0]) < 0) m_err = 1;
        else begin
          m_switch(mode_new);
          m_st[4:0] = mode_new;
          m_done = 1;
        end
      end else if (upd_en) begin
        case (upd_sel)
          2'd0: m_r29 = upd_data;
          2'd1: m_r30 = upd_data;
          2'd2: m_pc  = upd_data;
          default: m_st = upd_data;
        endcase
      end
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%08h exp=%08h", tag, what, got, exp);
    end
  endtask

  task automatic cmp_model(string tag);
    chk(tag, "pc", pc, m_pc);
    chk(tag, "r29", r29, m_r29);
    chk(tag, "r30", r30, m_r30);
    chk(tag, "bsr", bsr, m_bsr);
    chk(tag, "status", status, m_st);
    chk(tag, "done", 32'(done), 32'(m_done));
    chk(tag, "err", 32'(err), 32'(m_err));
  endtask

  task automatic clear_in();
    exc_req = 0; mode_req = 0; upd_en = 0; ctrl = 0;
    exc_cause = 0; mode_new = 0; upd_sel = 0; upd_data = 0;
  endtask

  task automatic step(string tag);
    @(posedge clk);
    @(negedge clk);
    cmp_model(tag);
    clear_in();
  endtask

  task automatic do_upd(logic [1:0] s, logic [31:0] d);
    upd_en = 1; upd_sel = s; upd_data = d;
    step("R12");
  endtask

  task automatic do_mode(logic [4:0] m, string tag);
    mode_req = 1; mode_new = m;
    step(tag);
  endtask

  task automatic do_exc(logic [2:0] c, bit hi, string tag);
    exc_req = 1; exc_cause = c; ctrl = hi ? 32'h0000_2000 : 32'h0;
    step(tag);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL R1 watchdog: got=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [4:0] mlist [7];
    mlist[0] = 5'h10; mlist[1] = 5'h1F; mlist[2] = 5'h13; mlist[3] = 5'h17;
    mlist[4] = 5'h1B; mlist[5] = 5'h12; mlist[6] = 5'h00;
    clear_in();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    cmp_model("R1");
    chk("R1", "status", status, 32'h13);
    chk("R1", "pc", pc, 0);

    do_upd(2'd0, 32'h1111_0001);
    chk("R12", "r29", r29, 32'h1111_0001);
    do_upd(2'd1, 32'h2222_0002);
    do_upd(2'd2, 32'h0000_0100);
    chk("R12", "done", 32'(done), 0);

    do_mode(5'h10, "R3");
    chk("R3", "r29", r29, 0);
    chk("R3", "status", status, 32'h10);
    chk("R3", "done", 32'(done), 1);
    do_upd(2'd0, 32'hAAAA_0000);
    do_mode(5'h1F, "R2");
    chk("R2", "r29", r29, 32'hAAAA_0000);
    do_mode(5'h13, "R3");
    chk("R3", "r29", r29, 32'h1111_0001);
    chk("R3", "r30", r30, 32'h2222_0002);
    do_mode(5'h13, "R4");
    chk("R4", "done", 32'(done), 1);
    chk("R4", "r29", r29, 32'h1111_0001);

    do_exc(3'd0, 0, "R9");
    chk("R9", "r29", r29, 32'h1111_0001);
    chk("R8", "r30", r30, 32'h100);
    chk("R5", "pc", pc, 32'h08);
    chk("R7", "status", status, 32'h93);
    chk("R7", "bsr", bsr, 32'h13);
    do_exc(3'd1, 1, "R6");
    chk("R6", "pc", pc, 32'hFFFF_000C);
    chk("R8", "r29", r29, 0);
    chk("R8", "r30", r30, 32'h08);
    chk("R5", "status", status, 32'h97);
    do_exc(3'd2, 0, "R9");
    chk("R5", "pc", pc, 32'h10);
    do_exc(3'd3, 0, "R5");
    chk("R5", "pc", pc, 32'h18);
    chk("R5", "status", status, 32'h92);

    do_exc(3'd5, 0, "R10");
    chk("R10", "err", 32'(err), 1);
    chk("R10", "pc", pc, 32'h18);
    do_mode(5'h00, "R10");
    chk("R10", "err", 32'(err), 1);
    do_upd(2'd3, 32'h0000_0001);
    do_exc(3'd0, 0, "R10");
    chk("R10", "done", 32'(done), 0);
    chk("R10", "pc", pc, 32'h18);
    do_upd(2'd3, 32'h0000_0092);

    exc_req = 1; exc_cause = 3'd0; mode_req = 1; mode_new = 5'h10;
    upd_en = 1; upd_sel = 2'd2; upd_data = 32'h5555;
    step("R11");
    chk("R11", "pc", pc, 32'h08);
    chk("R11", "mode", 32'(status[4:0]), 32'h13);
    mode_req = 1; mode_new = 5'h1B; upd_en = 1; upd_sel = 2'd0; upd_data = 32'h7777;
    step("R11");
    chk("R11", "r29", r29, 0);
    chk("R11", "mode", 32'(status[4:0]), 32'h1B);

    for (int n = 0; n < 600; n++) begin
      exc_req   = ($urandom_range(0, 3) == 0);
      exc_cause = 3'($urandom_range(0, 4) == 0 ? $urandom_range(4, 7) : $urandom_range(0, 3));
      mode_req  = ($urandom_range(0, 2) == 0);
      mode_new  = mlist[$urandom_range(0, 6)];
      ctrl      = ($urandom_range(0, 1) == 1) ? 32'h0000_2000 : 32'h0;
      upd_en    = ($urandom_range(0, 1) == 1);
      upd_sel   = 2'($urandom_range(0, 3));
      upd_data  = $urandom;
      if (upd_sel == 2'd3 && $urandom_range(0, 7) != 0)
        upd_data = {upd_data[31:5], mlist[$urandom_range(0, 5)]};
      step("R11");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule